// File: doc/BRIEF.md
# Counted-enable interrupt aggregator

The block collects interrupt requests from a fixed set of sources and merges them into one processor interrupt line. Each source has a level request input, an enable counter and a required enable count set by a parameter. The source is enabled only while its counter equals that required count. A source with several enabling conditions therefore needs every one of them switched on before it can raise an interrupt. A source is pending when its latched request is set, it is enabled, and it has a non-zero vector.

Enable and disable steps arrive on a small command stream. Each command names a source and a direction. Sources can be linked into chains. A step that lands on a group entry is passed along to the next member, and so is a step on an entry with no vector. Once a step has been passed along, it keeps moving down the chain. A 4-bit encoded level input drives the members of one chain directly: it selects one position to assert and fully enable, and it deasserts every other member. For the processor, the block reports the vector of the lowest-numbered pending source, or an all-ones code when nothing is pending or the processor mask is at its maximum.

Top module: `intc_agg`

## Requirements
- R1: A source is enabled only while its enable counter equals its parameter count. A source whose count is 2 stays off after one enable step and turns on after the second.
- R2: `pend_o[i]` is 1 exactly when source i has its request latched, is enabled, and has a non-zero vector. It updates on the clock edge that registers the change which caused it.
- R3: An enable step on a source already at its count leaves the counter unchanged. A disable step on a source whose counter is 0 also leaves it unchanged. A single disable step removes the enable from a fully enabled source.
- R4: `irq_o` is 1 exactly when at least one bit of `pend_o` is 1. It comes from a running count of pending sources that moves by the number that became pending minus the number that stopped.
- R5: A request is latched on a rising change of `req_i[i]` and cleared on a falling change, both relative to the previous cycle's sample. A level that holds steady leaves the latched request unchanged.
- R6: `vec_o` carries the vector of the lowest-indexed pending source. When no source is pending it carries all ones.
- R7: When `cpu_mask_i` equals 15, `vec_o` is all ones whatever is pending.
- R8: A step on a source with no vector that has a chain link is repeated on the linked source. From then on each linked member passes the step further along, even if it has a vector. A step sent straight to a source that has a vector goes no further.
- R9: A step on a reserved source is ignored and is not passed on. A reserved source has no chain link and either no vector or a required count of 0.
- R10: `cmd_ready_o` is 1 only while no command is in progress. A command transfers on a cycle with `cmd_valid_i` and `cmd_ready_o` both 1. Each chain member then takes one cycle, and `cmd_ready_o` stays 0 until the last step has been applied.
- R11: A change on `irl_lvl_i` targets position 15 XOR level in the chain that follows `IRL_HEAD`; position 0 is the head's first link. The member at that position gets its request latched and its counter set to its count. Every other member has its request cleared. Level 0 therefore clears every member of a chain shorter than 16. If a request edge arrives in the same cycle, the level input takes precedence.
- R12: Reset clears every counter, every latched request, the pending count and the command walker. After reset `pend_o` is 0, `irq_o` is 0, `vec_o` is all ones and `cmd_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SRC | Level request per source |
| irl_lvl_i | input | 4 | Encoded level, 0 means none, 15 is highest |
| cmd_valid_i | input | 1 | Enable command valid |
| cmd_ready_o | output | 1 | Enable command ready |
| cmd_idx_i | input | IDX_W | Source addressed by the command |
| cmd_on_i | input | 1 | 1 for an enable step, 0 for a disable step |
| cpu_mask_i | input | 4 | Processor interrupt mask level |
| pend_o | output | NUM_SRC | Pending flag per source |
| irq_o | output | 1 | Combined processor interrupt request |
| vec_o | output | VEC_W | Vector of the first pending source, all ones for none |

A command source may hold `cmd_valid_i` high with stable fields for as long as `cmd_ready_o` is low. Nothing is taken until both are high on the same edge.

## Verification
On every cycle the assertions check these properties:
- the interrupt line agrees with the pending flags;
- the running pending count equals the number of pending flags;
- the none code appears whenever no source is pending or the mask is at 15;
- no counter goes above its required count;
- every pending source is at its full count;
- the ready signal drops after each accepted command.

Only the bench scenarios can show the following:
- multi-step enabling and saturation;
- how far a step travels down a chain;
- that reserved sources are ignored;
- edge-only request latching;
- the order in which the encoded level selects chain positions.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W = 4;
  localparam logic [LVL_W-1:0] LVL_ALL = '1;

  typedef enum logic {
    WLK_IDLE = 1'b0,
    WLK_STEP = 1'b1
  } wlk_state_e;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell #(
  parameter int CNT_W   = 2,
  parameter int MAX     = 1,
  parameter bit HAS_VEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             step_en_i,
  input  logic             step_on_i,
  input  logic             irl_hit_i,
  input  logic             irl_sel_i,
  output logic             pend_d_o,
  output logic             pend_q_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX);

  logic             req_prev_q;
  logic             asrt_q, asrt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // latched request: the encoded level wins, otherwise input edges
  always_comb begin
    asrt_d = asrt_q;
    if (irl_hit_i)
      asrt_d = irl_sel_i;
    else if (req_i && !req_prev_q)
      asrt_d = 1'b1;
    else if (!req_i && req_prev_q)
      asrt_d = 1'b0;
  end

  // enable counter saturates at both ends
  always_comb begin
    cnt_d = cnt_q;
    if (irl_hit_i && irl_sel_i)
      cnt_d = CNT_MAX;
    else if (step_en_i) begin
      if (step_on_i && (cnt_q < CNT_MAX))
        cnt_d = cnt_q + 1'b1;
      else if (!step_on_i && (cnt_q != '0))
        cnt_d = cnt_q - 1'b1;
    end
  end

  assign pend_d_o = HAS_VEC && asrt_d && (cnt_d == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      asrt_q     <= 1'b0;
      cnt_q      <= '0;
      pend_q_o   <= 1'b0;
    end else begin
      req_prev_q <= req_i;
      asrt_q     <= asrt_d;
      cnt_q      <= cnt_d;
      pend_q_o   <= pend_d_o;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/intc_chain_walker.sv
module intc_chain_walker
  import intc_pkg::*;
#(
  parameter int                    NUM_SRC  = 8,
  parameter int                    IDX_W    = 3,
  parameter logic [NUM_SRC-1:0]    VEC_NZ   = '1,
  parameter logic [NUM_SRC-1:0]    MAX_ZERO = '0,
  parameter logic [NUM_SRC-1:0]    HAS_LINK = '0,
  parameter logic [NUM_SRC*IDX_W-1:0] LINK  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic             cmd_on_i,
  output logic             step_en_o,
  output logic [IDX_W-1:0] step_idx_o,
  output logic             step_on_o
);
  wlk_state_e       state_q;
  logic [IDX_W-1:0] cur_q;
  logic             on_q, grp_q;

  logic             cur_rsv, cur_vec, cur_has_link;
  logic [IDX_W-1:0] cur_link;

  // per-entry attributes of the current chain position
  always_comb begin
    cur_rsv      = 1'b1;
    cur_vec      = 1'b0;
    cur_has_link = 1'b0;
    cur_link     = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cur_q == IDX_W'(i)) begin
        cur_vec      = VEC_NZ[i];
        cur_has_link = HAS_LINK[i];
        cur_link     = LINK[i*IDX_W +: IDX_W];
        cur_rsv      = !HAS_LINK[i] && (!VEC_NZ[i] || MAX_ZERO[i]);
      end
    end
  end

  logic go_on;
  assign go_on = !cur_rsv && (grp_q || !cur_vec) && cur_has_link;

  assign cmd_ready_o = (state_q == WLK_IDLE);
  assign step_en_o   = (state_q == WLK_STEP) && !cur_rsv;
  assign step_idx_o  = cur_q;
  assign step_on_o   = on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WLK_IDLE;
      cur_q   <= '0;
      on_q    <= 1'b0;
      grp_q   <= 1'b0;
    end else begin
      unique case (state_q)
        WLK_IDLE: if (cmd_valid_i) begin
          state_q <= WLK_STEP;
          cur_q   <= cmd_idx_i;
          on_q    <= cmd_on_i;
          grp_q   <= 1'b0;
        end
        WLK_STEP: if (go_on) begin
          cur_q <= cur_link;
          grp_q <= 1'b1;
        end else begin
          state_q <= WLK_IDLE;
        end
        default: state_q <= WLK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intc_vec_pick.sv
module intc_vec_pick
  import intc_pkg::*;
#(
  parameter int                        NUM_SRC = 8,
  parameter int                        VEC_W   = 12,
  parameter logic [NUM_SRC*VEC_W-1:0]  SRC_VEC = '0
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [LVL_W-1:0]   mask_i,
  output logic [VEC_W-1:0]   vec_o
);
  always_comb begin
    vec_o = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = SRC_VEC[i*VEC_W +: VEC_W];
    end
    if (mask_i == LVL_ALL) vec_o = '1;
  end
endmodule

// File: rtl/intc_agg.sv
module intc_agg
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 2,
  parameter int VEC_W   = 12,
  parameter int IDX_W   = $clog2(NUM_SRC),
  parameter logic [NUM_SRC*VEC_W-1:0] SRC_VEC =
    {12'h2A0, 12'h280, 12'h000, 12'h260, 12'h240, 12'h000, 12'h220, 12'h200},
  parameter logic [NUM_SRC*CNT_W-1:0] SRC_MAX =
    {2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd2, 2'd1},
  parameter logic [NUM_SRC-1:0] SRC_HAS_LINK = 8'b0100_1100,
  parameter logic [NUM_SRC*IDX_W-1:0] SRC_LINK =
    {3'd0, 3'd7, 3'd0, 3'd0, 3'd4, 3'd3, 3'd0, 3'd0},
  parameter int IRL_HEAD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [3:0]         irl_lvl_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [IDX_W-1:0]   cmd_idx_i,
  input  logic               cmd_on_i,
  input  logic [3:0]         cpu_mask_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int PC_W = $clog2(NUM_SRC + 1);

  // position of a source in the chain behind IRL_HEAD, -1 when not a member
  function automatic int chain_pos(input int src);
    int cur;
    cur = IRL_HEAD;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (cur < 0 || cur >= NUM_SRC) return -1;
      if (!SRC_HAS_LINK[cur]) return -1;
      cur = int'(SRC_LINK[cur*IDX_W +: IDX_W]);
      if (cur == src) return (k < 16) ? k : -1;
    end
    return -1;
  endfunction

  function automatic logic [NUM_SRC-1:0] vec_nz_mask();
    logic [NUM_SRC-1:0] m;
    for (int i = 0; i < NUM_SRC; i++) m[i] = (SRC_VEC[i*VEC_W +: VEC_W] != '0);
    return m;
  endfunction

  function automatic logic [NUM_SRC-1:0] max_zero_mask();
    logic [NUM_SRC-1:0] m;
    for (int i = 0; i < NUM_SRC; i++) m[i] = (SRC_MAX[i*CNT_W +: CNT_W] == '0);
    return m;
  endfunction

  localparam logic [NUM_SRC-1:0] VEC_NZ   = vec_nz_mask();
  localparam logic [NUM_SRC-1:0] MAX_ZERO = max_zero_mask();

  // command walker
  logic             step_en, step_on;
  logic [IDX_W-1:0] step_idx;

  intc_chain_walker #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .VEC_NZ  (VEC_NZ),
    .MAX_ZERO(MAX_ZERO),
    .HAS_LINK(SRC_HAS_LINK),
    .LINK    (SRC_LINK)
  ) walk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid_i(cmd_valid_i),
    .cmd_ready_o(cmd_ready_o),
    .cmd_idx_i  (cmd_idx_i),
    .cmd_on_i   (cmd_on_i),
    .step_en_o  (step_en),
    .step_idx_o (step_idx),
    .step_on_o  (step_on)
  );

  // encoded level change detection
  logic [3:0] irl_prev_q;
  logic       irl_apply;
  logic [3:0] irl_target;

  assign irl_apply  = (irl_lvl_i != irl_prev_q);
  assign irl_target = irl_lvl_i ^ 4'hF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irl_prev_q <= '0;
    else        irl_prev_q <= irl_lvl_i;
  end

  // per-source state
  logic [NUM_SRC-1:0]       pend_d, pend_q;
  logic [NUM_SRC*CNT_W-1:0] cnt_all;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int POS = chain_pos(g);
    logic hit, sel;
    if (POS >= 0) begin : g_member
      assign hit = irl_apply;
      assign sel = (irl_target == 4'(POS));
    end else begin : g_plain
      assign hit = 1'b0;
      assign sel = 1'b0;
    end

    intc_src_cell #(
      .CNT_W  (CNT_W),
      .MAX    (int'(SRC_MAX[g*CNT_W +: CNT_W])),
      .HAS_VEC(VEC_NZ[g])
    ) cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i[g]),
      .step_en_i(step_en && (step_idx == IDX_W'(g))),
      .step_on_i(step_on),
      .irl_hit_i(hit),
      .irl_sel_i(sel),
      .pend_d_o (pend_d[g]),
      .pend_q_o (pend_q[g]),
      .cnt_o    (cnt_all[g*CNT_W +: CNT_W])
    );
  end

  // running count of pending sources
  logic [PC_W-1:0] pend_cnt_q, pend_cnt_d;

  always_comb begin
    pend_cnt_d = pend_cnt_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_d[i] && !pend_q[i]) pend_cnt_d = pend_cnt_d + 1'b1;
      if (!pend_d[i] && pend_q[i]) pend_cnt_d = pend_cnt_d - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_cnt_q <= '0;
    else        pend_cnt_q <= pend_cnt_d;
  end

  assign irq_o  = (pend_cnt_q != '0);
  assign pend_o = pend_q;

  intc_vec_pick #(
    .NUM_SRC(NUM_SRC),
    .VEC_W  (VEC_W),
    .SRC_VEC(SRC_VEC)
  ) pick_i (
    .pend_i(pend_q),
    .mask_i(cpu_mask_i),
    .vec_o (vec_o)
  );
endmodule

// File: rtl/intc_agg_chk.sv
module intc_agg_chk #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 2,
  parameter int VEC_W   = 12,
  parameter int PC_W    = 4,
  parameter logic [NUM_SRC*CNT_W-1:0] SRC_MAX = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] pend_o,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [3:0]         cpu_mask_i,
  input logic               cmd_valid_i,
  input logic               cmd_ready_o,
  input logic [NUM_SRC*CNT_W-1:0] cnt_all,
  input logic [PC_W-1:0]    pend_cnt_q
);
  a_r4_irq_follows_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_o != '0));

  a_r4_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt_q) == $countones(pend_o));

  a_r6_none_code: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == '0) |-> (vec_o == '1));

  a_r7_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mask_i == 4'hF) |-> (vec_o == '1));

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_all[g*CNT_W +: CNT_W] <= SRC_MAX[g*CNT_W +: CNT_W]);
    a_r2_pend_full: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[g] |-> (cnt_all[g*CNT_W +: CNT_W] == SRC_MAX[g*CNT_W +: CNT_W]));
  end
endmodule

bind intc_agg intc_agg_chk #(
  .NUM_SRC(NUM_SRC),
  .CNT_W  (CNT_W),
  .VEC_W  (VEC_W),
  .PC_W   ($clog2(NUM_SRC + 1)),
  .SRC_MAX(SRC_MAX)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pend_o     (pend_o),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .cpu_mask_i (cpu_mask_i),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .cnt_all    (cnt_all),
  .pend_cnt_q (pend_cnt_q)
);

// File: tb/intc_agg_tb.sv
module intc_agg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int CW    = 2;
  localparam int VW    = 12;
  localparam int IW    = 3;
  localparam int HEAD  = 2;
  localparam logic [N*VW-1:0] P_VEC =
    {12'h2A0, 12'h280, 12'h000, 12'h260, 12'h240, 12'h000, 12'h220, 12'h200};
  localparam logic [N*CW-1:0] P_MAX =
    {2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd2, 2'd1};
  localparam logic [N-1:0]    P_HL  = 8'b0100_1100;
  localparam logic [N*IW-1:0] P_LNK =
    {3'd0, 3'd7, 3'd0, 3'd0, 3'd4, 3'd3, 3'd0, 3'd0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [3:0]    lvl = '0;
  logic          cvalid = 1'b0;
  logic          cready;
  logic [IW-1:0] cidx = '0;
  logic          con = 1'b0;
  logic [3:0]    mask = '0;
  logic [N-1:0]  pend;
  logic          irq;
  logic [VW-1:0] vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_agg #(
    .NUM_SRC(N), .CNT_W(CW), .VEC_W(VW), .IDX_W(IW),
    .SRC_VEC(P_VEC), .SRC_MAX(P_MAX), .SRC_HAS_LINK(P_HL),
    .SRC_LINK(P_LNK), .IRL_HEAD(HEAD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .irl_lvl_i(lvl),
    .cmd_valid_i(cvalid), .cmd_ready_o(cready), .cmd_idx_i(cidx),
    .cmd_on_i(con), .cpu_mask_i(mask), .pend_o(pend), .irq_o(irq),
    .vec_o(vec)
  );

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  // reference model state
  bit       m_asrt [N];
  int       m_cnt  [N];
  bit       m_rprev[N];
  logic [3:0] m_lprev;

  function automatic int f_max(int i);  return int'(P_MAX[i*CW +: CW]); endfunction
  function automatic int f_vec(int i);  return int'(P_VEC[i*VW +: VW]); endfunction
  function automatic int f_lnk(int i);  return int'(P_LNK[i*IW +: IW]); endfunction

  function automatic int f_pos(int src);
    int cur = HEAD;
    for (int k = 0; k < N; k++) begin
      if (!P_HL[cur]) return -1;
      cur = f_lnk(cur);
      if (cur == src) return k;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++)
      p[i] = (f_vec(i) != 0) && m_asrt[i] && (m_cnt[i] == f_max(i));
    return p;
  endfunction

  function automatic logic [VW-1:0] exp_vec(logic [N-1:0] p, logic [3:0] mk);
    if (mk == 4'hF) return '1;
    for (int i = 0; i < N; i++) if (p[i]) return VW'(f_vec(i));
    return '1;
  endfunction

  // one clock edge with the current req/lvl (R5, R11)
  function automatic void model_edge(logic [N-1:0] r, logic [3:0] l);
    bit apply = (l != m_lprev);
    for (int i = 0; i < N; i++) begin
      int p = f_pos(i);
      if (apply && p >= 0) begin
        m_asrt[i] = (p == int'(l ^ 4'hF));
        if (m_asrt[i]) m_cnt[i] = f_max(i);
      end else if (r[i] && !m_rprev[i]) m_asrt[i] = 1'b1;
      else if (!r[i] && m_rprev[i]) m_asrt[i] = 1'b0;
      m_rprev[i] = r[i];
    end
    m_lprev = l;
  endfunction

  // full command walk (R3, R8, R9)
  function automatic void model_cmd(int idx, bit on);
    int cur = idx;
    bit grp = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!P_HL[cur] && (f_vec(cur) == 0 || f_max(cur) == 0)) return;
      if (on && m_cnt[cur] < f_max(cur)) m_cnt[cur]++;
      else if (!on && m_cnt[cur] > 0) m_cnt[cur]--;
      if ((grp || f_vec(cur) == 0) && P_HL[cur]) begin
        cur = f_lnk(cur);
        grp = 1'b1;
      end else return;
    end
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag);
    logic [N-1:0] p = exp_pend();
    chk({tag, " R2 pend"}, 32'(pend), 32'(p));
    chk({tag, " R4 irq"}, 32'(irq), 32'(p != '0));
    chk({tag, " R6 vec"}, 32'(vec), 32'(exp_vec(p, mask)));
  endtask

  // called at a negedge; ends at a negedge after the walk completes
  task automatic send_cmd(int idx, bit on);
    cvalid = 1'b1; cidx = IW'(idx); con = on;
    @(posedge clk); model_edge(req, lvl);
    @(negedge clk);
    cvalid = 1'b0;
    chk("R10 busy", 32'(cready), 32'd0);
    while (!cready) begin
      @(posedge clk); model_edge(req, lvl);
      @(negedge clk);
    end
    model_cmd(idx, on);
  endtask

  task automatic tick();
    @(posedge clk); model_edge(req, lvl);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_asrt[i] = 0; m_cnt[i] = 0; m_rprev[i] = 0;
    end
    m_lprev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 pend", 32'(pend), 32'd0);
    chk("R12 irq", 32'(irq), 32'd0);
    chk("R12 vec", 32'(vec), 32'hFFF);
    chk("R12 ready", 32'(cready), 32'd1);

    // R1: source 1 needs two enable steps
    req[1] = 1'b1; tick();
    send_cmd(1, 1'b1);
    chk("R1 one step", 32'(pend[1]), 32'd0);
    send_cmd(1, 1'b1);
    chk("R1 two steps", 32'(pend[1]), 32'd1);
    chk("R6 src1 vec", 32'(vec), 32'h220);
    // R3: extra enable saturates, one disable removes it
    send_cmd(1, 1'b1);
    send_cmd(1, 1'b0);
    chk("R3 saturate", 32'(pend[1]), 32'd0);
    chk_out("R3");
    // R9: reserved source 5 ignores enable
    req[5] = 1'b1; tick();
    send_cmd(5, 1'b1);
    chk("R9 reserved", 32'(pend[5]), 32'd0);
    // R8: group head 2 enables 3 and 4
    req[3] = 1'b1; req[4] = 1'b1; tick();
    send_cmd(2, 1'b1);
    chk("R8 chain 3", 32'(pend[3]), 32'd1);
    chk("R8 chain 4", 32'(pend[4]), 32'd1);
    // R8: direct step on vectored 6 does not reach 7
    req[6] = 1'b1; req[7] = 1'b1; tick();
    send_cmd(6, 1'b1); send_cmd(7, 1'b1);
    chk("R8 stop 6", 32'(pend[6]), 32'd1);
    chk("R8 stop 7", 32'(pend[7]), 32'd0);
    chk_out("R8");
    // R7 mask at 15
    mask = 4'hF; #1;
    chk("R7 masked", 32'(vec), 32'hFFF);
    mask = 4'h0;
    // R5: steady level holds latch
    tick(); tick();
    chk_out("R5 steady");
    // R11 encoded level
    lvl = 4'd15; tick(); chk_out("R11 lvl15");
    chk("R11 pos0", 32'(pend[3]), 32'd1);
    chk("R11 pos1 off", 32'(pend[4]), 32'd0);
    lvl = 4'd14; tick(); chk_out("R11 lvl14");
    lvl = 4'd0;  tick(); chk_out("R11 lvl0");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int a = int'($urandom % 10);
      if (a < 4) begin
        req[$urandom % N] ^= 1'b1; tick(); chk_out("R5 rnd");
      end else if (a < 6) begin
        lvl = 4'($urandom); tick(); chk_out("R11 rnd");
      end else if (a < 7) begin
        mask = 4'($urandom); tick(); chk_out("R7 rnd");
      end else begin
        send_cmd(int'($urandom % N), 1'($urandom)); chk_out("R8 rnd");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule